// File: doc/BRIEF.md
# Migration Pointer Table

This block is a per-tile, set-associative table that tracks where migrated cache lines currently sit. An entry of the local kind belongs to a line whose home is this tile but which now lives in another tile's bank. An entry of the remote kind is a cached pointer for a line that this tile used recently and whose home is elsewhere. A lookup that hits gives the current host tile ID straight away, so the requester does not have to go through the home tile. Every entry also carries a directory vector with one bit per tile. At a local entry, this vector records which tiles hold a remote copy of the pointer.

Requests arrive on a valid/ready channel. Each request carries an operation, a tag, a host ID, a kind flag and a tile number. Results leave on a valid/ready response channel. Only one request is in flight at a time: a request is accepted only when the response register is empty or is being drained in the same cycle. The response then appears in the next cycle and stays stable until it is taken. When a line migrates, the home tile sends a host-rewrite request. The response carries the directory vector as a fan-out mask, which tells the network layer which remote pointers must also be rewritten. Victim choice protects local entries, because evicting a local entry would also mean dropping the line itself and every remote copy of its pointer. No home-tile field is stored: the home tile is derived from the line's address by the caller.

Top module: `mpt_table`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is 0, `req_ready` is 1, and any lookup misses.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` equals NOT `rsp_valid` OR `rsp_ready`. The response is valid in the cycle after acceptance, and it holds all its fields stable while `rsp_ready` is 0.
- R3: A lookup (op code 0) on a tag that is present returns `rsp_hit`=1, together with the stored host ID and kind (`rsp_local`=1 for a local entry). A lookup on an absent tag returns `rsp_hit`=0.
- R4: An allocate (op code 1) stores the tag, host ID and kind (`req_local`), with an empty directory. The set is chosen by the low log2(SETS) bits of the tag, so each set holds WAYS entries independently of the other sets.
- R5: An allocate whose tag already exists in the set overwrites that entry and creates no second copy. It reports `rsp_hit`=1, updates the host and kind, and clears the directory.
- R6: An add-sharer request (op code 2) on a tag held as a local entry sets bit `req_tile` of that entry's directory and returns `rsp_hit`=1. On a remote or absent tag it returns `rsp_hit`=0 and changes no entry.
- R7: A host-rewrite request (op code 3) on a present tag replaces its host ID with `req_host` and returns `rsp_hit`=1. For a local entry, `rsp_mask` is the entry's directory vector. For a remote entry, and for any other operation, `rsp_mask` is 0.
- R8: When the tag is absent, an allocate takes the lowest-numbered invalid way. If no way is invalid, it takes the least-recently-used remote entry.
- R9: A local entry is never chosen as a victim. If every way in the set is a valid local entry, the allocate returns `rsp_fail`=1 and `rsp_hit`=0, and the table is unchanged.
- R10: A lookup hit, a successful allocate and a host-rewrite hit each make the touched entry the most recently used in its set. An add-sharer request leaves the recency order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 lookup, 1 allocate, 2 add sharer, 3 host rewrite |
| req_tag | input | TAG_W | Line tag; low bits select the set |
| req_host | input | log2(TILES) | Host ID for allocate or rewrite |
| req_local | input | 1 | Allocate kind: 1 local, 0 remote |
| req_tile | input | log2(TILES) | Tile number for add sharer |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_hit | output | 1 | Tag matched (see R3, R5 to R7) |
| rsp_fail | output | 1 | Allocate found no way to use |
| rsp_local | output | 1 | Kind of the matched or written entry |
| rsp_host | output | log2(TILES) | Host ID of the matched or written entry |
| rsp_mask | output | TILES | Fan-out mask from a host rewrite |

## Verification
A corrupted tag, kind or host field shows up at the next lookup of that line, as a miss or as a wrong `rsp_host` one cycle after the request. A broken recency order stays hidden until a full set of remote entries overflows. At that point the wrong surviving line reveals it, so the bench fills sets completely and then probes every line. An error in directory bookkeeping appears only in the mask returned by the next host rewrite of that line.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_ALLOC  = 2'd1,
    OP_SHARE  = 2'd2,
    OP_REHOST = 2'd3
  } mpt_op_e;
endpackage

// File: rtl/mpt_way_match.sv
module mpt_way_match #(
  parameter int WAYS  = 16,
  parameter int TAG_W = 22,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             vld [WAYS],
  input  logic [TAG_W-1:0] tag [WAYS],
  input  logic [TAG_W-1:0] key,
  output logic             hit,
  output logic [WAY_W-1:0] way
);
  // lowest matching way wins; a correct table never holds two
  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld[w] && tag[w] == key) begin
        hit = 1'b1;
        way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/mpt_victim_pick.sv
module mpt_victim_pick #(
  parameter int WAYS = 16,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int RANK_W = $clog2(WAYS)
) (
  input  logic              vld  [WAYS],
  input  logic              loc  [WAYS],
  input  logic [RANK_W-1:0] rank [WAYS],
  output logic              found,
  output logic [WAY_W-1:0]  way
);
  logic              inv_f;
  logic [WAY_W-1:0]  inv_w;
  logic              rem_f;
  logic [WAY_W-1:0]  rem_w;
  logic [RANK_W-1:0] rem_r;

  always_comb begin
    inv_f = 1'b0;
    inv_w = '0;
    rem_f = 1'b0;
    rem_w = '0;
    rem_r = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!vld[w] && !inv_f) begin
        inv_f = 1'b1;
        inv_w = WAY_W'(w);
      end
      if (vld[w] && !loc[w] && (!rem_f || rank[w] > rem_r)) begin
        rem_f = 1'b1;
        rem_w = WAY_W'(w);
        rem_r = rank[w];
      end
    end
    found = inv_f || rem_f;
    way   = inv_f ? inv_w : rem_w;
  end
endmodule

// File: rtl/mpt_lru_ranks.sv
module mpt_lru_ranks #(
  parameter int SETS = 8,
  parameter int WAYS = 16,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int RANK_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  output logic [RANK_W-1:0] rd_rank [WAYS],
  input  logic              touch_en,
  input  logic [SET_W-1:0]  touch_set,
  input  logic [WAY_W-1:0]  touch_way
);
  // rank 0 = most recent, WAYS-1 = least recent
  logic [RANK_W-1:0] rank_q [SETS][WAYS];
  logic [RANK_W-1:0] cur_rank;

  always_comb begin
    for (int w = 0; w < WAYS; w++) rd_rank[w] = rank_q[rd_set][w];
    cur_rank = rank_q[touch_set][touch_way];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          rank_q[s][w] <= RANK_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          rank_q[touch_set][w] <= '0;
        else if (rank_q[touch_set][w] < cur_rank)
          rank_q[touch_set][w] <= rank_q[touch_set][w] + 1'b1;
      end
    end
  end

  // checking aids: remember the last touch
  logic             chk_t_q;
  logic [SET_W-1:0] chk_s_q;
  logic [WAY_W-1:0] chk_w_q;
  logic [WAYS-1:0]  seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_t_q <= 1'b0;
      chk_s_q <= '0;
      chk_w_q <= '0;
    end else begin
      chk_t_q <= touch_en;
      chk_s_q <= touch_set;
      chk_w_q <= touch_way;
    end
  end

  always_comb begin
    seen = '0;
    for (int w = 0; w < WAYS; w++) seen[rank_q[chk_s_q][w]] = 1'b1;
  end

  assert_touch_mru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_t_q |-> rank_q[chk_s_q][chk_w_q] == '0);

  assert_rank_perm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chk_t_q |-> &seen);
endmodule

// File: rtl/mpt_table.sv
module mpt_table #(
  parameter int TAG_W = 22,
  parameter int TILES = 16,
  parameter int WAYS  = 16,
  parameter int SETS  = 8,
  localparam int HOST_W = $clog2(TILES),
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = $clog2(WAYS),
  localparam int RANK_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [HOST_W-1:0] req_host,
  input  logic              req_local,
  input  logic [HOST_W-1:0] req_tile,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_fail,
  output logic              rsp_local,
  output logic [HOST_W-1:0] rsp_host,
  output logic [TILES-1:0]  rsp_mask
);
  import mpt_pkg::*;

  // entry storage
  logic              ent_vld  [SETS][WAYS];
  logic              ent_loc  [SETS][WAYS];
  logic [TAG_W-1:0]  ent_tag  [SETS][WAYS];
  logic [TILES-1:0]  ent_dir  [SETS][WAYS];
  logic [HOST_W-1:0] ent_host [SETS][WAYS];

  mpt_op_e           op;
  logic              acc;
  logic [SET_W-1:0]  set_idx;
  logic              cur_vld [WAYS];
  logic              cur_loc [WAYS];
  logic [TAG_W-1:0]  cur_tag [WAYS];
  logic [RANK_W-1:0] cur_rank [WAYS];

  logic              m_hit;
  logic [WAY_W-1:0]  m_way;
  logic              v_found;
  logic [WAY_W-1:0]  v_way;
  logic              alloc_ok;
  logic [WAY_W-1:0]  alloc_way;
  logic              m_local;
  logic              touch_en;
  logic [WAY_W-1:0]  touch_way;
  mpt_op_e           rsp_op_q;

  assign op        = mpt_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign set_idx   = req_tag[SET_W-1:0];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      cur_vld[w] = ent_vld[set_idx][w];
      cur_loc[w] = ent_loc[set_idx][w];
      cur_tag[w] = ent_tag[set_idx][w];
    end
  end

  mpt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
    .vld(cur_vld), .tag(cur_tag), .key(req_tag), .hit(m_hit), .way(m_way)
  );

  mpt_victim_pick #(.WAYS(WAYS)) victim_i (
    .vld(cur_vld), .loc(cur_loc), .rank(cur_rank), .found(v_found), .way(v_way)
  );

  mpt_lru_ranks #(.SETS(SETS), .WAYS(WAYS)) lru_i (
    .clk(clk), .rst_n(rst_n), .rd_set(set_idx), .rd_rank(cur_rank),
    .touch_en(touch_en), .touch_set(set_idx), .touch_way(touch_way)
  );

  assign alloc_ok  = m_hit || v_found;
  assign alloc_way = m_hit ? m_way : v_way;
  assign m_local   = m_hit && cur_loc[m_way];
  assign touch_way = (op == OP_ALLOC) ? alloc_way : m_way;
  assign touch_en  = acc && (((op == OP_LOOKUP || op == OP_REHOST) && m_hit) ||
                             (op == OP_ALLOC && alloc_ok));

  // valid bits and response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ent_vld[s][w] <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_local <= 1'b0;
      rsp_host  <= '0;
      rsp_mask  <= '0;
      rsp_op_q  <= OP_LOOKUP;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_op_q  <= op;
      rsp_fail  <= 1'b0;
      rsp_mask  <= '0;
      rsp_hit   <= m_hit;
      rsp_local <= m_local;
      rsp_host  <= m_hit ? ent_host[set_idx][m_way] : '0;
      case (op)
        OP_ALLOC: begin
          rsp_fail  <= !alloc_ok;
          rsp_local <= alloc_ok && req_local;
          rsp_host  <= alloc_ok ? req_host : '0;
          if (alloc_ok) ent_vld[set_idx][alloc_way] <= 1'b1;
        end
        OP_SHARE: begin
          rsp_hit <= m_local;
        end
        OP_REHOST: begin
          if (m_hit) rsp_host <= req_host;
          if (m_local) rsp_mask <= ent_dir[set_idx][m_way];
        end
        default: ;
      endcase
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // entry payload writes
  always_ff @(posedge clk) begin
    if (acc) begin
      if (op == OP_ALLOC && alloc_ok) begin
        ent_tag[set_idx][alloc_way]  <= req_tag;
        ent_loc[set_idx][alloc_way]  <= req_local;
        ent_host[set_idx][alloc_way] <= req_host;
        ent_dir[set_idx][alloc_way]  <= '0;
      end
      if (op == OP_SHARE && m_local)
        ent_dir[set_idx][m_way][req_tile] <= 1'b1;
      if (op == OP_REHOST && m_hit)
        ent_host[set_idx][m_way] <= req_host;
    end
  end

  assert_rsp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) && $stable(rsp_fail)
      && $stable(rsp_host) && $stable(rsp_local) && $stable(rsp_mask));

  assert_victim_not_local_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && op == OP_ALLOC && !m_hit && v_found |-> !(cur_vld[v_way] && cur_loc[v_way]));

  assert_fail_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fail |-> !rsp_hit);

  assert_mask_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_mask != '0 |-> rsp_op_q == OP_REHOST && rsp_local && rsp_hit);
endmodule

// File: tb/mpt_table_tb_top.sv
module mpt_table_tb_top;
  localparam int TAG_W = 22;
  localparam int TILES = 16;
  localparam int WAYS  = 16;
  localparam int SETS  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [3:0] req_host = '0;
  logic req_local = 1'b0;
  logic [3:0] req_tile = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_hit, rsp_fail, rsp_local;
  logic [3:0] rsp_host;
  logic [TILES-1:0] rsp_mask;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mpt_table #(.TAG_W(TAG_W), .TILES(TILES), .WAYS(WAYS), .SETS(SETS)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_tag(req_tag), .req_host(req_host), .req_local(req_local),
    .req_tile(req_tile), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_fail(rsp_fail), .rsp_local(rsp_local),
    .rsp_host(rsp_host), .rsp_mask(rsp_mask)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TAG_W-1:0] tg(input int k, input int s);
    return TAG_W'((k << 3) | s);
  endfunction

  task automatic send(input int op, input logic [TAG_W-1:0] t, input int host,
                      input bit loc, input int tile);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = 2'(op);
    req_tag   = t;
    req_host  = 4'(host);
    req_local = loc;
    req_tile  = 4'(tile);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2 response one cycle later", rsp_valid, 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic expect_lookup(input logic [TAG_W-1:0] t, input bit hit,
                               input int host, input bit loc, input string req);
    send(0, t, 0, 0, 0);
    chk(rsp_hit == hit, req, rsp_hit, hit);
    if (hit) begin
      chk(rsp_host == 4'(host), req, rsp_host, host);
      chk(rsp_local == loc, req, rsp_local, loc);
    end
  endtask

  initial begin
    logic [3:0] held;
    do_reset();
    // R1: reset state
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    expect_lookup(tg(5, 1), 0, 0, 0, "R1 empty table misses");

    // R4: fill every set with local entries, then read all back (R3)
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++) begin
        send(1, tg(k, s), (k + s) % 16, 1, 0);
        chk(rsp_fail == 1'b0, "R4 alloc into free way", rsp_fail, 0);
      end
    for (int s = 0; s < SETS; s++)
      for (int k = 0; k < WAYS; k++)
        expect_lookup(tg(k, s), 1, (k + s) % 16, 1, "R3 R4 lookup stored host");

    // R9: set full of local entries refuses allocation
    send(1, tg(40, 0), 9, 0, 0);
    chk(rsp_fail == 1'b1, "R9 full local set fails", rsp_fail, 1);
    chk(rsp_hit == 1'b0, "R9 fail without hit", rsp_hit, 0);
    expect_lookup(tg(40, 0), 0, 0, 0, "R9 refused tag absent");
    for (int k = 0; k < WAYS; k++)
      expect_lookup(tg(k, 0), 1, k, 1, "R9 locals kept");

    // R5: overwrite an existing tag
    send(1, tg(1, 1), 12, 1, 0);
    chk(rsp_hit == 1'b1 && rsp_fail == 1'b0, "R5 overwrite reports match", rsp_hit, 1);
    expect_lookup(tg(1, 1), 1, 12, 1, "R5 overwritten host");
    send(2, tg(2, 2), 0, 0, 7);
    send(1, tg(2, 2), 3, 1, 0);
    send(3, tg(2, 2), 5, 0, 0);
    chk(rsp_mask == '0, "R5 overwrite clears directory", rsp_mask, 0);

    // R6 R7: sharer bits and host rewrite
    send(2, tg(4, 2), 0, 0, 3);
    chk(rsp_hit == 1'b1, "R6 add sharer on local", rsp_hit, 1);
    send(2, tg(4, 2), 0, 0, 9);
    send(3, tg(4, 2), 11, 0, 0);
    chk(rsp_hit == 1'b1, "R7 rewrite hit", rsp_hit, 1);
    chk(rsp_mask == 16'h0208, "R7 fan-out mask", rsp_mask, 16'h0208);
    chk(rsp_host == 4'd11, "R7 rewrite host echo", rsp_host, 11);
    expect_lookup(tg(4, 2), 1, 11, 1, "R7 new host visible");
    send(2, tg(20, 2), 0, 0, 1);
    chk(rsp_hit == 1'b0, "R6 add sharer on absent tag", rsp_hit, 0);
    send(0, tg(4, 2), 0, 0, 0);
    chk(rsp_mask == '0, "R7 mask zero on lookup", rsp_mask, 0);

    // R1: reset empties the table
    do_reset();
    expect_lookup(tg(4, 2), 0, 0, 0, "R1 reset clears entries");

    // R8 R10: remote fill, touches, LRU eviction
    for (int k = 0; k < WAYS; k++) send(1, tg(k, 4), k, 0, 0);
    send(0, tg(0, 4), 0, 0, 0);
    send(0, tg(1, 4), 0, 0, 0);
    send(2, tg(2, 4), 0, 0, 5);
    chk(rsp_hit == 1'b0, "R6 add sharer on remote", rsp_hit, 0);
    send(1, tg(100, 4), 7, 0, 0);
    chk(rsp_fail == 1'b0 && rsp_hit == 1'b0, "R8 alloc evicts remote", rsp_fail, 0);
    expect_lookup(tg(2, 4), 0, 0, 0, "R8 R10 LRU remote evicted");
    expect_lookup(tg(0, 4), 1, 0, 0, "R10 touched entry kept");
    expect_lookup(tg(1, 4), 1, 1, 0, "R10 touched entry kept");
    expect_lookup(tg(100, 4), 1, 7, 0, "R8 new remote present");
    send(3, tg(3, 4), 2, 0, 0);
    chk(rsp_mask == '0 && rsp_hit == 1'b1, "R7 remote rewrite mask zero", rsp_mask, 0);
    expect_lookup(tg(3, 4), 1, 2, 0, "R7 remote host rewritten");
    // rewrite touched k3; next LRU is k4
    send(1, tg(101, 4), 1, 0, 0);
    expect_lookup(tg(4, 4), 0, 0, 0, "R10 rewrite refreshes recency");
    expect_lookup(tg(3, 4), 1, 2, 0, "R10 rewritten entry kept");

    // R9: single remote among locals is the only victim
    for (int k = 0; k < WAYS - 1; k++) send(1, tg(k, 5), k, 1, 0);
    send(1, tg(15, 5), 15, 0, 0);
    send(1, tg(50, 5), 6, 1, 0);
    chk(rsp_fail == 1'b0, "R9 remote replaced", rsp_fail, 0);
    expect_lookup(tg(15, 5), 0, 0, 0, "R9 remote evicted");
    expect_lookup(tg(50, 5), 1, 6, 1, "R9 new local present");
    expect_lookup(tg(0, 5), 1, 0, 1, "R9 LRU local untouched");
    send(1, tg(51, 5), 6, 0, 0);
    chk(rsp_fail == 1'b1, "R9 all-local set refuses", rsp_fail, 1);

    // R8: invalid ways used before any eviction
    for (int k = 0; k < WAYS; k++) send(1, tg(k, 6), k, 0, 0);
    for (int k = 0; k < WAYS; k++)
      expect_lookup(tg(k, 6), 1, k, 0, "R8 invalid ways filled first");

    // R2: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    req_op = 2'd0;
    req_tag = tg(5, 6);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R2 response raised", rsp_valid, 1);
    chk(req_ready == 1'b0, "R2 ready low while stalled", req_ready, 0);
    held = rsp_host;
    chk(held == 4'd5, "R2 stalled data", held, 5);
    @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_host == held, "R2 held stable", rsp_host, held);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 drained", rsp_valid, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule